// File: doc/BRIEF.md
# Flash Data Polling Controller

This block runs on the host side of a parallel NOR flash and decides when an embedded program or erase operation inside the flash has finished. After software or a command sequencer has launched the operation, a single-cycle `start` hands the block a polling address and the byte that is expected once the operation completes. For a program, the polling address is the programmed location. For a sector erase, any address inside the sector being erased will do. For a chip erase, any address in an unprotected sector will do.

The controller then performs read cycles on a simple parallel read port: an address, active-high chip-enable and output-enable strobes, and a data input. On each read it compares bit 7 of the returned byte with bit 7 of the expected byte. If they match, the operation is complete. If they do not match, it looks at bit 5, the device's timeout indicator. A set bit 5 triggers exactly one confirming re-read, because bit 7 can settle in the same cycle as bit 5. An optional limit on the number of ordinary polls ends a poll that never resolves. The block reports the outcome with a one-cycle `done` pulse and a held `pass` or `fail` flag.

Top module: `nor_poll_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_ce`, `rd_oe`, `busy`, `done`, `pass` and `fail` are all 0.
- R2: Every read asserts `rd_ce` and `rd_oe` together for exactly STROBE_CYC consecutive cycles. The byte on `rd_data` in the last of those cycles is the byte used for the decision.
- R3: Between two reads of the same poll, `rd_ce` and `rd_oe` stay low for at least GAP_CYC cycles.
- R4: If bit 7 of a read byte equals bit 7 of the expected byte, the poll ends with a pass after that read, whatever bit 5 of that byte holds.
- R5: If bit 7 differs and bit 5 is 0, another read is issued, unless the poll limit of R7 is reached.
- R6: If bit 7 differs and bit 5 is 1, exactly one more read follows. That read alone decides the outcome: a matching bit 7 is a pass, a differing bit 7 is a fail, and its bit 5 is ignored.
- R7: When MAX_POLLS is non-zero and the MAX_POLLS-th read ends with bit 7 differing and bit 5 at 0, the poll ends with a fail. A value of 0 disables the limit. The re-read of R6 is not counted against the limit.
- R8: A `start` while `busy` is high is ignored. It does not change the polled address, the expected bit, the number of reads or the outcome.
- R9: `done` is high for exactly one cycle at the end of a poll, and `busy` is low in that cycle. At most one of `pass` and `fail` is high. The flag holds until a new `start` is accepted, and both flags are 0 from the cycle after that accept.
- R10: `poll_addr` and bit 7 of `expect_data` are captured when `start` is accepted. `rd_addr` shows the captured address during every strobe of the poll, and later changes on the inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request to begin polling |
| poll_addr | input | ADDR_W | Address to poll |
| expect_data | input | DATA_W | Byte expected once the operation is complete (bit 7 used) |
| rd_addr | output | ADDR_W | Read address to the flash |
| rd_ce | output | 1 | Chip-enable strobe, active high |
| rd_oe | output | 1 | Output-enable strobe, active high |
| rd_data | input | DATA_W | Data returned by the flash |
| busy | output | 1 | A poll is in progress |
| done | output | 1 | One-cycle pulse when a poll ends |
| pass | output | 1 | Last poll completed successfully |
| fail | output | 1 | Last poll failed (timeout bit or poll limit) |

## Verification
The bench builds the controller with STROBE_CYC=3, GAP_CYC=2 and MAX_POLLS=6. A three-cycle strobe and a two-cycle gap make exact strobe-width and minimum-gap violations visible. A limit of six reads lets short byte scripts reach the poll limit, including the case where bit 5 rises on the sixth read and the uncounted re-read still has to happen. A 16-bit address lets the bench inject an inverted address and flipped expected byte mid-poll and see at once whether either reached the read port.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

    // Bit positions the flash drives during an embedded operation.
    localparam int FLAG_BIT    = 7;
    localparam int TIMEOUT_BIT = 5;

    typedef enum logic [1:0] {
        RC_IDLE,
        RC_STROBE,
        RC_GAP
    } rc_phase_e;

    typedef enum logic [2:0] {
        V_NONE,
        V_PASS,
        V_FAIL,
        V_AGAIN,
        V_RECHECK
    } verdict_e;

endpackage

// File: rtl/nor_poll_rdcyc.sv
module nor_poll_rdcyc
    import nor_poll_pkg::*;
#(
    parameter int STROBE_CYC = 4,
    parameter int GAP_CYC    = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic strobe,
    output logic sample,
    output logic ready
);

    localparam int SPAN = (STROBE_CYC > GAP_CYC) ? STROBE_CYC : GAP_CYC;
    localparam int CW   = $clog2(SPAN + 1);
    localparam logic [CW-1:0] LAST_S = CW'(STROBE_CYC - 1);
    localparam logic [CW-1:0] LAST_G = CW'(GAP_CYC - 1);

    typedef struct packed {
        rc_phase_e       phase;
        logic [CW-1:0]   cnt;
    } rc_state_t;

    rc_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        sample = 1'b0;
        ready  = 1'b0;
        case (s_q.phase)
            RC_IDLE: begin
                ready = 1'b1;
                if (launch) begin
                    s_d.phase = RC_STROBE;
                    s_d.cnt   = '0;
                end
            end
            RC_STROBE: begin
                if (s_q.cnt == LAST_S) begin
                    sample    = 1'b1;
                    s_d.phase = RC_GAP;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            RC_GAP: begin
                if (s_q.cnt == LAST_G) begin
                    ready = 1'b1;
                    s_d.cnt = '0;
                    s_d.phase = launch ? RC_STROBE : RC_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: begin
                s_d.phase = RC_IDLE;
                s_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.phase <= RC_IDLE;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign strobe = (s_q.phase == RC_STROBE);

    // R2: a strobe that has not reached its sampling cycle stays asserted
    p_strobe_len_r2: assert property (@(posedge clk) disable iff (rst)
        (strobe && !sample) |=> strobe);

    // R3: the cycle after sampling always has the strobes low
    p_gap_after_sample_r3: assert property (@(posedge clk) disable iff (rst)
        sample |=> !strobe);

endmodule

// File: rtl/nor_poll_limit.sv
module nor_poll_limit #(
    parameter int MAX_POLLS = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic at_limit
);

    localparam int CW = $clog2(MAX_POLLS + 2);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (bump && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    generate
        if (MAX_POLLS == 0) begin : g_unlimited
            assign at_limit = 1'b0;
        end else begin : g_limited
            assign at_limit = (cnt_q == CW'(MAX_POLLS - 1));

            // R7: the read count never runs past the limit
            p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
                cnt_q <= CW'(MAX_POLLS));
        end
    endgenerate

endmodule

// File: rtl/nor_poll_judge.sv
module nor_poll_judge
    import nor_poll_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rd_byte,
    input  logic              exp_flag,
    input  logic              recheck,
    input  logic              at_limit,
    output verdict_e          verdict
);

    logic flag_match;
    logic unused_bits;

    assign flag_match  = (rd_byte[FLAG_BIT] == exp_flag);
    assign unused_bits = ^rd_byte;

    always_comb begin
        if (recheck) begin
            verdict = flag_match ? V_PASS : V_FAIL;
        end else if (flag_match) begin
            verdict = V_PASS;
        end else if (rd_byte[TIMEOUT_BIT]) begin
            verdict = V_RECHECK;
        end else if (at_limit) begin
            verdict = V_FAIL;
        end else begin
            verdict = V_AGAIN;
        end
    end

endmodule

// File: rtl/nor_poll_ctrl.sv
module nor_poll_ctrl
    import nor_poll_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 8,
    parameter int STROBE_CYC = 4,
    parameter int GAP_CYC    = 1,
    parameter int MAX_POLLS  = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] poll_addr,
    input  logic [DATA_W-1:0] expect_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ce,
    output logic              rd_oe,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail
);

    typedef struct packed {
        logic              busy;
        logic              recheck;
        logic              done;
        logic              pass;
        logic              fail;
        logic              exp_flag;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t     c_d, c_q;
    logic     accept;
    logic     launch;
    logic     strobe;
    logic     sample;
    logic     ready;
    logic     at_limit;
    logic     bump;
    verdict_e verdict;
    logic     unused_expect;

    assign unused_expect = ^expect_data;

    nor_poll_rdcyc #(
        .STROBE_CYC (STROBE_CYC),
        .GAP_CYC    (GAP_CYC)
    ) u_rdcyc (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .strobe (strobe),
        .sample (sample),
        .ready  (ready)
    );

    nor_poll_limit #(
        .MAX_POLLS (MAX_POLLS)
    ) u_limit (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .bump     (bump),
        .at_limit (at_limit)
    );

    nor_poll_judge #(
        .DATA_W (DATA_W)
    ) u_judge (
        .rd_byte  (rd_data),
        .exp_flag (c_q.exp_flag),
        .recheck  (c_q.recheck),
        .at_limit (at_limit),
        .verdict  (verdict)
    );

    assign accept = start && !c_q.busy;
    assign launch = (c_q.busy || accept) && ready;
    assign bump   = c_q.busy && sample && !c_q.recheck;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        if (accept) begin
            c_d.busy     = 1'b1;
            c_d.recheck  = 1'b0;
            c_d.pass     = 1'b0;
            c_d.fail     = 1'b0;
            c_d.addr     = poll_addr;
            c_d.exp_flag = expect_data[FLAG_BIT];
        end else if (c_q.busy && sample) begin
            case (verdict)
                V_PASS: begin
                    c_d.busy = 1'b0;
                    c_d.done = 1'b1;
                    c_d.pass = 1'b1;
                end
                V_FAIL: begin
                    c_d.busy = 1'b0;
                    c_d.done = 1'b1;
                    c_d.fail = 1'b1;
                end
                V_RECHECK: begin
                    c_d.recheck = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_addr = c_q.addr;
    assign rd_ce   = strobe;
    assign rd_oe   = strobe;
    assign busy    = c_q.busy;
    assign done    = c_q.done;
    assign pass    = c_q.pass;
    assign fail    = c_q.fail;

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: a finished poll is never still busy, and the outcome is exclusive
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && (pass != fail)));

    // R9: a held outcome only drops when a new start is taken
    p_hold_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        ((pass || fail) && !start) |=> $stable({pass, fail}));

    // R8 / R10: a start during a poll leaves the captured target untouched
    p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(rd_addr) && $stable(c_q.exp_flag)));

    // R6: the confirming read always ends the poll
    p_recheck_final_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && c_q.recheck && sample) |-> (verdict == V_PASS || verdict == V_FAIL));

    // R2: strobes only run while a poll is active or just ending
    p_strobe_busy_r2: assert property (@(posedge clk) disable iff (rst)
        rd_ce |-> busy);

endmodule

// File: tb/nor_poll_ctrl_tb.sv
module nor_poll_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 16;
    localparam int DW   = 8;
    localparam int SCYC = 3;
    localparam int GCYC = 2;
    localparam int MAXP = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [AW-1:0] poll_addr;
    logic [DW-1:0] expect_data;
    logic [AW-1:0] rd_addr;
    logic          rd_ce, rd_oe;
    logic [DW-1:0] rd_data;
    logic          busy, done, pass, fail;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nor_poll_ctrl #(
        .ADDR_W     (AW),
        .DATA_W     (DW),
        .STROBE_CYC (SCYC),
        .GAP_CYC    (GAP_CYC_FIX()),
        .MAX_POLLS  (MAXP)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .poll_addr   (poll_addr),
        .expect_data (expect_data),
        .rd_addr     (rd_addr),
        .rd_ce       (rd_ce),
        .rd_oe       (rd_oe),
        .rd_data     (rd_data),
        .busy        (busy),
        .done        (done),
        .pass        (pass),
        .fail        (fail)
    );

    function automatic int GAP_CYC_FIX();
        return GCYC;
    endfunction

    typedef struct {
        bit    ok;
        int    reads;
        string tag;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] script[$];
    int            idx;
    logic [AW-1:0] exp_addr;
    int            checks = 0;
    int            fails  = 0;
    bit            done_seen;
    bit            prev_ce;
    bit            prev_done;
    bit            bad_strobe;
    bit            seen_read;
    int            hi_run, lo_run;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Flash model: drives the scripted byte of the current read
    always_comb begin
        if (idx < script.size()) rd_data = script[idx];
        else                     rd_data = 8'h00;
    end

    // Monitor: strobe shape, address, and scoreboard comparison
    always @(negedge clk) begin
        if (rst) begin
            prev_ce   <= 1'b0;
            prev_done <= 1'b0;
            hi_run    <= 0;
            lo_run    <= 0;
            seen_read <= 1'b0;
        end else begin
            if (rd_ce) begin
                if (rd_oe !== 1'b1 || rd_addr !== exp_addr) bad_strobe = 1'b1;
                if (!prev_ce && seen_read && busy)
                    chk(lo_run >= GCYC, "R3", "gap cycles", lo_run, GCYC);
                hi_run = prev_ce ? hi_run + 1 : 1;
            end else begin
                if (rd_oe !== 1'b0) bad_strobe = 1'b1;
                lo_run = prev_ce ? 1 : lo_run + 1;
            end
            if (prev_ce && !rd_ce) begin
                idx = idx + 1;
                seen_read = 1'b1;
                chk(hi_run == SCYC, "R2", "strobe width", hi_run, SCYC);
                chk(!bad_strobe, "R10", "address/oe during strobe", int'(bad_strobe), 0);
                bad_strobe = 1'b0;
            end
            if (prev_done) chk(!done, "R9", "done width", int'(done), 0);
            if (done) begin
                exp_t e;
                chk(sb.size() > 0, "R9", "unexpected done", sb.size(), 1);
                if (sb.size() > 0) begin
                    e = sb.pop_front();
                    chk(pass == e.ok && fail == !e.ok, e.tag, "pass flag",
                        int'(pass), int'(e.ok));
                    chk(idx == e.reads, e.tag, "read count", idx, e.reads);
                    chk(!busy, "R9", "busy at done", int'(busy), 0);
                end
                done_seen = 1'b1;
            end
            prev_ce   = rd_ce;
            prev_done = done;
        end
    end

    function automatic void predict(input logic [DW-1:0] e, output bit ok, output int n);
        ok = 1'b0;
        n  = 0;
        for (int i = 0; i < script.size(); i++) begin
            n = i + 1;
            if (script[i][7] == e[7]) begin ok = 1'b1; return; end
            if (script[i][5]) begin
                n  = i + 2;
                ok = (script[i+1][7] == e[7]);
                return;
            end
            if (n == MAXP) return;
        end
    endfunction

    // Driver: loads the script, predicts the outcome, pushes it, starts a poll
    task automatic run_poll(input logic [AW-1:0] a, input logic [DW-1:0] e,
                            input logic [DW-1:0] bytes[$], input bit poke,
                            input string tag);
        exp_t x;
        script    = bytes;
        idx       = 0;
        exp_addr  = a;
        done_seen = 1'b0;
        predict(e, x.ok, x.reads);
        x.tag = tag;
        sb.push_back(x);
        @(negedge clk);
        poll_addr   = a;
        expect_data = e;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!pass && !fail, "R9", "flags cleared after start", int'(pass | fail), 0);
        chk(busy, "R9", "busy after start", int'(busy), 1);
        if (poke) begin
            @(negedge clk);
            poll_addr   = ~a;
            expect_data = ~e;
            start       = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done_seen) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; poll_addr = '0; expect_data = '0;
        idx = 0; exp_addr = '0; bad_strobe = 1'b0;
        repeat (3) @(negedge clk);
        chk(!rd_ce && !rd_oe && !busy && !done && !pass && !fail, "R1",
            "outputs in reset", int'({rd_ce, rd_oe, busy, done, pass, fail}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!rd_ce && !busy && !pass && !fail, "R1", "outputs after reset",
            int'({rd_ce, busy, pass, fail}), 0);

        // R4: first read already matches
        run_poll(16'h1234, 8'h80, '{8'h80}, 1'b0, "R4");
        // R4: match wins even with bit 5 set
        run_poll(16'h0042, 8'h80, '{8'hA0}, 1'b0, "R4");
        // R5: several clean mismatches, then a match
        run_poll(16'hBEEF, 8'h35, '{8'h80, 8'hC0, 8'h80, 8'h35}, 1'b0, "R5");
        // R6: bit 5 then a matching re-read
        run_poll(16'h0F0F, 8'h80, '{8'h00, 8'h20, 8'h80}, 1'b0, "R6");
        // R6: bit 5 then a mismatching re-read (its bit 5 ignored)
        run_poll(16'h7777, 8'h80, '{8'h20, 8'h60, 8'h80}, 1'b0, "R6");
        repeat (10) @(negedge clk);
        chk(fail && !pass, "R9", "fail held while idle", int'(fail), 1);
        // R7: limit reached
        run_poll(16'hA5A5, 8'h80, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                    8'h80, 8'h80}, 1'b0, "R7");
        // R7: bit 5 on the last counted read still gets its re-read
        run_poll(16'h5A5A, 8'h80, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h20,
                                    8'h80}, 1'b0, "R7");
        // R8 / R10: start and new inputs mid-poll are ignored
        run_poll(16'h3C3C, 8'h00, '{8'h80, 8'h80, 8'h80, 8'h00}, 1'b1, "R8");
        repeat (10) @(negedge clk);
        chk(pass && !fail, "R9", "pass held while idle", int'(pass), 1);
        chk(!rd_ce, "R8", "no extra read after ignored start", int'(rd_ce), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule